// File: doc/BRIEF.md
# Sequential Display Write Controller

This block is the host-facing write port of a multiplexed LED display controller. A host drives an 8-bit bus, a select line that tells control traffic from display data, and an active-low write strobe that need not be related to the system clock. The strobe is brought into the clock domain, and the block acts once per strobe, when the strobe is released. The bus and the select line are sampled at that moment.

A control word sets three mode flags for the scan and decode logic downstream: shutdown or run, raw segments or decoded digits, and hexadecimal or the alternate character set. It also says whether display bytes follow. Once armed, the block stores each data byte at the next display memory slot, starting at slot 0, and keeps the display blanked until every slot has been filled. It then locks itself out until the next control word. A single slot cannot be rewritten on its own. In decode mode the stored byte keeps only the decimal point and the 4-bit character code, and the unused bits are cleared.

Top module: `seqdisp_wr_ctrl`

## Requirements
- R1: After reset, run_o, raw_o, hex_o and blank_o are 0, and mem_we_o stays 0 until an armed data write.
- R2: A write takes effect once per strobe, when wr_ni returns high. Nothing happens while the strobe is low. The result appears on the registered outputs within six clock cycles of the release.
- R3: A write with sel_ctrl_i = 1 is a control word. It loads run_o from bus bit 4 (1 = run, 0 = shutdown), raw_o from bit 5 (1 = raw segments, 0 = decode) and hex_o from bit 6 (1 = hexadecimal, 0 = alternate set). Bits 3..0 have no effect.
- R4: A control word with bus bit 7 = 1 arms the block and restarts the slot address at 0. blank_o is 1 exactly while the block is armed.
- R5: While armed, each write with sel_ctrl_i = 0 gives one cycle of mem_we_o. The slot addresses run 0, 1, 2 and upward, one per write, and mem_data_o carries the stored byte.
- R6: After DEPTH armed data writes, the block disarms and blank_o falls. Further data writes give no mem_we_o until a new control word arrives.
- R7: A control word with bit 7 = 0 updates the flags and leaves the block disarmed. Data writes that arrive while the block is disarmed, including those before the first control word, are ignored. A control word sent in the middle of a sequence restarts it.
- R8: Data writes are stored while run_o = 0 (shutdown).
- R9: With raw_o = 0, the stored byte keeps bit 7 (decimal point) and bits 3..0 (character code) and clears bits 6..4. With raw_o = 1, the byte is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Host write strobe, active low, asynchronous |
| sel_ctrl_i | input | 1 | 1 = control word, 0 = display byte; sampled at strobe release |
| bus_i | input | 8 | Host data bus; sampled at strobe release |
| mem_we_o | output | 1 | One-cycle display memory write enable |
| mem_addr_o | output | $clog2(DEPTH) | Display memory slot being written |
| mem_data_o | output | 8 | Byte written to the display memory |
| run_o | output | 1 | 1 = display running, 0 = shutdown |
| raw_o | output | 1 | 1 = raw segment bytes, 0 = decoded characters |
| hex_o | output | 1 | 1 = hexadecimal set, 0 = alternate set |
| blank_o | output | 1 | Display blanked while a byte sequence is in progress |

## Verification
The bench builds the block with its defaults: DEPTH = 8, SYNC_STAGES = 2 and the decode-mode byte masking enabled. With these values, the full eight-slot sequence, the lock-out on the ninth write and the cleared bits 6..4 in decode mode can all be reached within a few dozen strobes. The two-stage synchroniser fixes the release-to-write latency at three cycles, which stays well inside the six-cycle observation window the bench uses after every strobe. Random mixes of control words and data bytes also restart sequences part-way through, and they arm and disarm the block in every flag combination.

// File: rtl/seqdisp_pkg.sv
package seqdisp_pkg;
   localparam int unsigned BUS_W  = 8;
   // control word bit positions (the downstream decoder relies on them)
   localparam int unsigned CW_RUN = 4;
   localparam int unsigned CW_RAW = 5;
   localparam int unsigned CW_HEX = 6;
   localparam int unsigned CW_ARM = 7;
   // decoded byte layout
   localparam int unsigned DP_BIT = 7;
   localparam int unsigned CODE_W = 4;

   typedef struct packed {
      logic hex;
      logic raw;
      logic run;
   } mode_flags_t;
endpackage

// File: rtl/seqdisp_strobe_sync.sv
module seqdisp_strobe_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic strobe_ni,
   output logic release_o
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   last_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= 1'b1;
            else         chain_q[0] <= strobe_ni;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= 1'b1;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b1;
      else         last_q <= chain_q[SYNC_STAGES-1];
   end

   assign release_o = chain_q[SYNC_STAGES-1] & ~last_q;

   // R2
   single_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      release_o |=> !release_o);
endmodule

// File: rtl/seqdisp_mode_reg.sv
module seqdisp_mode_reg
   import seqdisp_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        load_i,
   input  logic [2:0]  word_i,
   output mode_flags_t flags_o
);
   mode_flags_t flags_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flags_q <= '0;
      end else if (load_i) begin
         flags_q.run <= word_i[CW_RUN-4];
         flags_q.raw <= word_i[CW_RAW-4];
         flags_q.hex <= word_i[CW_HEX-4];
      end
   end

   assign flags_o = flags_q;

   // R3
   flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(load_i) |-> $stable(flags_o));
endmodule

// File: rtl/seqdisp_sequencer.sv
module seqdisp_sequencer
   import seqdisp_pkg::*;
#(
   parameter int unsigned DEPTH   = 8,
   parameter bit          MASK_DC = 1'b1,
   localparam int unsigned AW     = $clog2(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ctrl_stb_i,
   input  logic             data_stb_i,
   input  logic             arm_i,
   input  logic             raw_i,
   input  logic [BUS_W-1:0] bus_i,
   output logic             we_o,
   output logic [AW-1:0]    addr_o,
   output logic [BUS_W-1:0] data_o,
   output logic             armed_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic             armed_q;
   logic [AW-1:0]    cnt_q;
   logic [BUS_W-1:0] store_byte;

   if (MASK_DC) begin : g_mask
      always_comb begin
         store_byte = bus_i;
         if (!raw_i) begin
            store_byte = '0;
            store_byte[DP_BIT]     = bus_i[DP_BIT];
            store_byte[CODE_W-1:0] = bus_i[CODE_W-1:0];
         end
      end
   end else begin : g_pass
      assign store_byte = bus_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         we_o    <= 1'b0;
         addr_o  <= '0;
         data_o  <= '0;
      end else begin
         we_o <= 1'b0;
         if (ctrl_stb_i) begin
            armed_q <= arm_i;
            cnt_q   <= '0;
         end else if (data_stb_i && armed_q) begin
            we_o   <= 1'b1;
            addr_o <= cnt_q;
            data_o <= store_byte;
            if (cnt_q == LAST) begin
               armed_q <= 1'b0;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign armed_o = armed_q;

   // R5
   we_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_o |-> $past(armed_q));

   // R6
   disarm_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(armed_q) |-> ((we_o && addr_o == LAST) || $past(ctrl_stb_i)));

   // R4
   arm_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(armed_q) |-> $past(ctrl_stb_i && arm_i));
endmodule

// File: rtl/seqdisp_wr_ctrl.sv
module seqdisp_wr_ctrl
   import seqdisp_pkg::*;
#(
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MASK_DC     = 1'b1,
   localparam int unsigned AW         = $clog2(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_ni,
   input  logic             sel_ctrl_i,
   input  logic [BUS_W-1:0] bus_i,
   output logic             mem_we_o,
   output logic [AW-1:0]    mem_addr_o,
   output logic [BUS_W-1:0] mem_data_o,
   output logic             run_o,
   output logic             raw_o,
   output logic             hex_o,
   output logic             blank_o
);
   logic        release_s;
   logic        ctrl_stb;
   logic        data_stb;
   mode_flags_t flags;

   seqdisp_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strobe_ni (wr_ni),
      .release_o (release_s)
   );

   assign ctrl_stb = release_s &  sel_ctrl_i;
   assign data_stb = release_s & ~sel_ctrl_i;

   seqdisp_mode_reg u_mode (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (ctrl_stb),
      .word_i  (bus_i[CW_HEX:CW_RUN]),
      .flags_o (flags)
   );

   seqdisp_sequencer #(.DEPTH(DEPTH), .MASK_DC(MASK_DC)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_stb_i (ctrl_stb),
      .data_stb_i (data_stb),
      .arm_i      (bus_i[CW_ARM]),
      .raw_i      (flags.raw),
      .bus_i      (bus_i),
      .we_o       (mem_we_o),
      .addr_o     (mem_addr_o),
      .data_o     (mem_data_o),
      .armed_o    (blank_o)
   );

   assign run_o = flags.run;
   assign raw_o = flags.raw;
   assign hex_o = flags.hex;

   // R9
   decode_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_we_o && !raw_o && MASK_DC) |-> (mem_data_o[6:4] == 3'b000));
endmodule

// File: tb/seqdisp_wr_ctrl_tb.sv
module seqdisp_wr_ctrl_tb;
   localparam int DEPTH = 8;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_n = 1'b1;
   logic          sel = 1'b0;
   logic [7:0]    bus = '0;
   logic          we;
   logic [AW-1:0] addr;
   logic [7:0]    mdata;
   logic          run, raw, hex, blank;

   always #4 clk = ~clk;  // 125 MHz

   seqdisp_wr_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n), .sel_ctrl_i(sel), .bus_i(bus),
      .mem_we_o(we), .mem_addr_o(addr), .mem_data_o(mdata),
      .run_o(run), .raw_o(raw), .hex_o(hex), .blank_o(blank)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // reference model state
   bit e_armed = 0;
   int e_cnt   = 0;
   bit e_run = 0, e_raw = 0, e_hex = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input logic [7:0] b, input bit is_raw);
      return is_raw ? b : {b[7], 3'b000, b[3:0]};
   endfunction

   task automatic op(input logic m, input logic [7:0] b);
      int nw_low = 0, nw = 0, got_a = 0, got_d = 0;
      bit exp_w = 0;
      int exp_a = 0;
      logic [7:0] exp_d = '0;
      string tag;
      @(negedge clk);
      sel = m; bus = b; wr_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (we) nw_low++;
      end
      wr_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (we) begin nw++; got_a = int'(addr); got_d = int'(mdata); end
      end
      // model
      if (m) begin
         e_run = b[4]; e_raw = b[5]; e_hex = b[6];
         e_armed = b[7]; e_cnt = 0;
         tag = "R3";
      end else if (e_armed) begin
         exp_w = 1; exp_a = e_cnt; exp_d = exp_byte(b, e_raw);
         tag = !e_run ? "R8" : (e_raw ? "R5" : "R9");
         e_cnt++;
         if (e_cnt == DEPTH) begin e_armed = 0; e_cnt = 0; end
      end else begin
         tag = "R6";
      end
      chk("R2", "writes while strobe low", nw_low, 0);
      chk(tag, "write count", nw, int'(exp_w));
      if (exp_w && nw == 1) begin
         chk(tag, "slot address", got_a, exp_a);
         chk(tag, "stored byte", got_d, int'(exp_d));
      end
      chk("R3", "run flag", int'(run), int'(e_run));
      chk("R3", "raw flag", int'(raw), int'(e_raw));
      chk("R3", "hex flag", int'(hex), int'(e_hex));
      chk("R4", "blank", int'(blank), int'(e_armed));
   endtask

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "run", int'(run), 0);
      chk("R1", "raw", int'(raw), 0);
      chk("R1", "hex", int'(hex), 0);
      chk("R1", "blank", int'(blank), 0);
      chk("R1", "we", int'(we), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R7: data before any control word is ignored
      op(1'b0, 8'h5A);
      // R4/R8/R9: arm in shutdown, decode mode, alternate set
      op(1'b1, 8'h80);
      for (int i = 0; i < DEPTH; i++) op(1'b0, 8'hF0 | 8'(i));
      // R6: ninth write locked out
      op(1'b0, 8'h77);
      // R3: low nibble ignored; raw, hex, run, armed
      op(1'b1, 8'hF5);
      op(1'b0, 8'hA5);
      op(1'b0, 8'h3C);
      op(1'b0, 8'h7E);
      // R7: restart part-way through
      op(1'b1, 8'h9A);
      op(1'b0, 8'hEE);
      // R7: control word without arm, then ignored data
      op(1'b1, 8'h30);
      op(1'b0, 8'hFF);
      // random mix
      for (int k = 0; k < 300; k++) begin
         logic m;
         logic [7:0] b;
         m = ($urandom % 5) == 0;
         b = 8'($urandom);
         if (m && ($urandom % 4) != 0) b[7] = 1'b1;
         op(m, b);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule